// File: doc/BRIEF.md
# Jabber and SQE Transmit Monitor

This block sits on the transmit side of a 10/100 Ethernet path, between the MAC's transmit-enable and the line driver. It counts how long transmit-enable stays high without a break. If a transmission runs past a set limit, the block locks out the transmitter. It holds the collision output high and keeps a gate closed so transmit-enable can no longer reach the driver. The lockout ends only after transmit-enable has been low, without a break, for a much longer quiet interval. When it ends, the gate reopens and collision drops.

In 10 Mbit/s operation the block also produces a signal-quality-error test pulse on the collision output after every packet. The pulse begins a fixed number of cycles after transmit-enable falls and lasts a fixed number of cycles. A mode input can force this pulse on or off at either speed. A sticky status flag records that a jabber lockout happened. A single-cycle read strobe clears it.

All time limits are parameters counted in clock cycles, so simulation can use short windows while silicon uses the real millisecond values.

Top module: `tx_jabber_guard`

## Requirements
- R1: When tx_en is sampled high on JAB_LIMIT+1 consecutive rising edges, col_out is 1 and tx_gate is 0 after that edge. A run of only JAB_LIMIT high edges causes no lockout.
- R2: While locked, col_out stays 1 and tx_gate stays 0 even when tx_en is high. A high sample of tx_en restarts the quiet count from zero.
- R3: While locked, once tx_en is sampled low on QUIET_LIMIT+1 consecutive edges, the lockout ends after that edge: col_out returns to 0 and the gate reopens. After only QUIET_LIMIT low edges the lockout is still in force.
- R4: While jab_disable is 1, no run of tx_en starts a lockout. Raising jab_disable during a lockout ends it after the next edge.
- R5: jab_flag becomes 1 on the edge that starts a lockout. It stays 1, including after release, until status_rd is high at an edge, which clears it. If a lockout starts on the same edge as a read, the flag is set.
- R6: Outside a lockout, tx_gate follows tx_en combinationally.
- R7: An SQE pulse, when allowed, begins on col_out SQE_DELAY edges after the edge that first samples tx_en low after a high. It lasts exactly SQE_LEN cycles.
- R8: sqe_mode encoding: 2'b00 and 2'b11 select automatic mode, where the pulse is on when speed_10=1 and off when speed_10=0; 2'b01 forces the pulse off; 2'b10 forces it on.
- R9: A fall of tx_en that is seen while the lockout is active starts no SQE pulse, even if the lockout ends on that same edge.
- R10: tx_en rising while an SQE pulse is still pending cancels it, and col_out stays 0 while tx_en remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit-enable from the MAC |
| speed_10 | input | 1 | 1 = 10 Mbit/s, 0 = 100 Mbit/s |
| jab_disable | input | 1 | 1 turns the jabber function off |
| sqe_mode | input | 2 | SQE pulse selection (see R8) |
| status_rd | input | 1 | Read strobe that clears jab_flag |
| tx_gate | output | 1 | Transmit-enable passed to the driver |
| col_out | output | 1 | Collision: jabber lockout or SQE pulse |
| jab_flag | output | 1 | Sticky jabber-timeout status |

## Verification
A run counter that is off by one moves the lockout one cycle early or late. The bench catches this on the exact edge where col_out must first rise, and the same applies to the release edge of the quiet counter. A stuck lockout state shows at once as a closed gate or a collision during normal traffic. A wrong SQE state or delay count shows within SQE_DELAY+SQE_LEN cycles of a packet's end. It appears as a shifted, stretched, missing or unwanted pulse on col_out. A flag that fails to hold, or fails to clear, shows on the first read after a lockout.

// File: rtl/jg_pkg.sv
package jg_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_WAIT  = 2'd1,
        SQ_PULSE = 2'd2
    } sqe_state_e;

    typedef struct packed {
        logic lock;
        logic flag;
        logic tx_prev;
    } guard_state_t;

    // 00/11: automatic (on only at 10 Mbit/s), 01: off, 10: on
    function automatic logic sqe_allowed(input logic [1:0] mode, input logic speed10);
        case (mode)
            2'b01:   sqe_allowed = 1'b0;
            2'b10:   sqe_allowed = 1'b1;
            default: sqe_allowed = speed10;
        endcase
    endfunction

endpackage

// File: rtl/jg_streak_counter.sv
module jg_streak_counter #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic hit
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (active) begin
            cnt_d = (cnt_q == LIM) ? cnt_q : cnt_q + 1'b1;
        end
    end

    assign hit = active && (cnt_q == LIM);

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/jg_sqe_pulser.sv
module jg_sqe_pulser
    import jg_pkg::*;
#(
    parameter int unsigned DELAY = 100,
    parameter int unsigned LEN   = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic pulse
);
    localparam int unsigned MAXC = (DELAY > LEN) ? DELAY : LEN;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DLY_LAST = CW'(DELAY - 1);
    localparam logic [CW-1:0] LEN_LAST = CW'(LEN - 1);

    typedef struct packed {
        sqe_state_e   st;
        logic [CW-1:0] cnt;
    } pulser_t;

    pulser_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (abort) begin
            p_d.st  = SQ_IDLE;
            p_d.cnt = '0;
        end else begin
            case (p_q.st)
                SQ_IDLE: begin
                    if (start) begin
                        p_d.st  = SQ_WAIT;
                        p_d.cnt = '0;
                    end
                end
                SQ_WAIT: begin
                    if (p_q.cnt == DLY_LAST) begin
                        p_d.st  = SQ_PULSE;
                        p_d.cnt = '0;
                    end else begin
                        p_d.cnt = p_q.cnt + 1'b1;
                    end
                end
                SQ_PULSE: begin
                    if (p_q.cnt == LEN_LAST) begin
                        p_d.st  = SQ_IDLE;
                        p_d.cnt = '0;
                    end else begin
                        p_d.cnt = p_q.cnt + 1'b1;
                    end
                end
                default: begin
                    p_d.st  = SQ_IDLE;
                    p_d.cnt = '0;
                end
            endcase
        end
    end

    assign pulse = (p_q.st == SQ_PULSE);

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '{st: SQ_IDLE, cnt: '0};
        else        p_q <= p_d;
    end
endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard
    import jg_pkg::*;
#(
    parameter int unsigned JAB_LIMIT   = 4_000_000,
    parameter int unsigned QUIET_LIMIT = 100_000_000,
    parameter int unsigned SQE_DELAY   = 100,
    parameter int unsigned SQE_LEN     = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       speed_10,
    input  logic       jab_disable,
    input  logic [1:0] sqe_mode,
    input  logic       status_rd,
    output logic       tx_gate,
    output logic       col_out,
    output logic       jab_flag
);
    guard_state_t st_d, st_q;

    logic run_active, run_hit;
    logic quiet_active, quiet_hit;
    logic sqe_ok, sqe_start, sqe_abort, sqe_pulse;

    assign run_active   = tx_en & ~st_q.lock & ~jab_disable;
    assign quiet_active = st_q.lock & ~tx_en & ~jab_disable;

    jg_streak_counter #(.LIMIT(JAB_LIMIT)) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (run_active),
        .hit    (run_hit)
    );

    jg_streak_counter #(.LIMIT(QUIET_LIMIT)) u_quiet (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (quiet_active),
        .hit    (quiet_hit)
    );

    assign sqe_ok    = sqe_allowed(sqe_mode, speed_10);
    assign sqe_start = st_q.tx_prev & ~tx_en & ~st_q.lock & sqe_ok;
    assign sqe_abort = tx_en | st_q.lock | ~sqe_ok;

    jg_sqe_pulser #(.DELAY(SQE_DELAY), .LEN(SQE_LEN)) u_sqe (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sqe_start),
        .abort  (sqe_abort),
        .pulse  (sqe_pulse)
    );

    always_comb begin
        st_d         = st_q;
        st_d.tx_prev = tx_en;
        if (jab_disable)    st_d.lock = 1'b0;
        else if (run_hit)   st_d.lock = 1'b1;
        else if (quiet_hit) st_d.lock = 1'b0;
        if (run_hit)        st_d.flag = 1'b1;
        else if (status_rd) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{lock: 1'b0, flag: 1'b0, tx_prev: 1'b0};
        else        st_q <= st_d;
    end

    assign tx_gate  = tx_en & ~st_q.lock;
    assign col_out  = st_q.lock | sqe_pulse;
    assign jab_flag = st_q.flag;
endmodule

// File: rtl/tx_jabber_guard_chk.sv
module tx_jabber_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic jab_disable,
    input logic status_rd,
    input logic tx_gate,
    input logic col_out,
    input logic jab_flag,
    input logic lock_q,
    input logic run_hit,
    input logic sqe_pulse
);
    // R6
    gate_needs_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_gate |-> tx_en);

    // R2
    lock_blocks_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |-> (!tx_gate && col_out));

    // R1
    lock_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(run_hit));

    // R3
    release_on_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> ($past(!tx_en) || $past(jab_disable)));

    // R4
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jab_disable |=> !lock_q);

    // R5
    flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_hit |=> jab_flag);

    // R5
    flag_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !run_hit) |=> !jab_flag);

    // R9
    no_sqe_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lock_q && sqe_pulse));
endmodule

bind tx_jabber_guard tx_jabber_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .jab_disable (jab_disable),
    .status_rd   (status_rd),
    .tx_gate     (tx_gate),
    .col_out     (col_out),
    .jab_flag    (jab_flag),
    .lock_q      (st_q.lock),
    .run_hit     (run_hit),
    .sqe_pulse   (sqe_pulse)
);

// File: tb/tx_jabber_guard_bench.sv
`timescale 1ns/100ps
module tx_jabber_guard_bench;
    localparam int unsigned JL = 20;
    localparam int unsigned QL = 30;
    localparam int unsigned SD = 3;
    localparam int unsigned SL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic speed_10 = 1'b0;
    logic jab_disable = 1'b0;
    logic [1:0] sqe_mode = 2'b00;
    logic status_rd = 1'b0;
    logic tx_gate, col_out, jab_flag;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles++;

    tx_jabber_guard #(
        .JAB_LIMIT(JL), .QUIET_LIMIT(QL), .SQE_DELAY(SD), .SQE_LEN(SL)
    ) u_tx_jabber_guard (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .speed_10(speed_10),
        .jab_disable(jab_disable), .sqe_mode(sqe_mode), .status_rd(status_rd),
        .tx_gate(tx_gate), .col_out(col_out), .jab_flag(jab_flag)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // trigger lockout from idle; returns after the triggering edge
    task automatic trigger_lock();
        tx_en = 1'b1;
        repeat (JL + 1) tick();
    endtask

    // release lockout with tx_en low
    task automatic release_lock();
        tx_en = 1'b0;
        repeat (QL + 1) tick();
    endtask

    // after tx_en has just been lowered: observe col_out after the fall edge
    task automatic sqe_probe(input bit expect_pulse, input string req);
        int first = -1;
        int count = 0;
        tick();
        chk({req, " col right after fall"}, int'(col_out), 0);
        for (int i = 1; i <= int'(SD + SL + 2); i++) begin
            tick();
            if (col_out) begin
                count++;
                if (first < 0) first = i;
            end
        end
        if (expect_pulse) begin
            chk({req, " pulse start"}, first, int'(SD));
            chk({req, " pulse length"}, count, int'(SL));
        end else begin
            chk({req, " no pulse"}, count, 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R6 reset gate", int'(tx_gate), 0);
        chk("R1 reset col", int'(col_out), 0);
        chk("R5 reset flag", int'(jab_flag), 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_jabber_boundary();
        speed_10 = 1'b0; sqe_mode = 2'b00;
        tx_en = 1'b1;
        #1;
        chk("R6 gate follows tx_en", int'(tx_gate), 1);
        repeat (JL) tick();
        chk("R1 no lock at limit", int'(col_out), 0);
        tx_en = 1'b0;
        tick();
        chk("R1 short run no col", int'(col_out), 0);
        chk("R1 short run no flag", int'(jab_flag), 0);
        tick();
        tx_en = 1'b1;
        repeat (JL) tick();
        chk("R1 col before trigger edge", int'(col_out), 0);
        tick();
        chk("R1 col after trigger", int'(col_out), 1);
        chk("R1 gate closed", int'(tx_gate), 0);
        chk("R5 flag set", int'(jab_flag), 1);
    endtask

    task automatic t_quiet_release();
        tx_en = 1'b0;
        repeat (QL) tick();
        chk("R3 still locked at limit", int'(col_out), 1);
        tx_en = 1'b1;
        tick();
        chk("R2 gate blocked while locked", int'(tx_gate), 0);
        chk("R2 col held", int'(col_out), 1);
        tx_en = 1'b0;
        repeat (QL) tick();
        chk("R2 quiet restarted", int'(col_out), 1);
        tick();
        chk("R3 released col", int'(col_out), 0);
        chk("R5 flag sticky after release", int'(jab_flag), 1);
        tx_en = 1'b1;
        #1;
        chk("R3 gate reopened", int'(tx_gate), 1);
        tx_en = 1'b0;
        tick();
        status_rd = 1'b1;
        tick();
        status_rd = 1'b0;
        chk("R5 flag cleared by read", int'(jab_flag), 0);
        tick();
    endtask

    task automatic t_flag_set_wins();
        tx_en = 1'b1;
        repeat (JL) tick();
        status_rd = 1'b1;
        tick();
        status_rd = 1'b0;
        chk("R5 set wins over read", int'(jab_flag), 1);
        release_lock();
        status_rd = 1'b1;
        tick();
        status_rd = 1'b0;
        tick();
    endtask

    task automatic t_disable();
        sqe_mode = 2'b01;
        jab_disable = 1'b1;
        tx_en = 1'b1;
        repeat (3 * JL) tick();
        chk("R4 no lock when disabled", int'(col_out), 0);
        chk("R4 gate open when disabled", int'(tx_gate), 1);
        tx_en = 1'b0;
        jab_disable = 1'b0;
        repeat (2) tick();
        trigger_lock();
        chk("R4 locked before disable", int'(col_out), 1);
        jab_disable = 1'b1;
        tick();
        chk("R4 disable ends lock", int'(col_out), 0);
        chk("R4 gate reopened", int'(tx_gate), 1);
        tx_en = 1'b0;
        jab_disable = 1'b0;
        repeat (2) tick();
        sqe_mode = 2'b00;
    endtask

    task automatic short_packet(input int len);
        tx_en = 1'b1;
        repeat (len) tick();
        tx_en = 1'b0;
    endtask

    task automatic t_sqe_modes();
        speed_10 = 1'b1; sqe_mode = 2'b00;
        short_packet(5);
        sqe_probe(1'b1, "R7 R8 auto at 10");
        speed_10 = 1'b0; sqe_mode = 2'b00;
        short_packet(5);
        sqe_probe(1'b0, "R8 auto at 100");
        speed_10 = 1'b0; sqe_mode = 2'b10;
        short_packet(5);
        sqe_probe(1'b1, "R8 forced on at 100");
        speed_10 = 1'b1; sqe_mode = 2'b01;
        short_packet(5);
        sqe_probe(1'b0, "R8 forced off at 10");
        speed_10 = 1'b1; sqe_mode = 2'b11;
        short_packet(7);
        sqe_probe(1'b1, "R7 R8 code 11 at 10");
        sqe_mode = 2'b00;
    endtask

    task automatic t_sqe_in_lock();
        int count = 0;
        speed_10 = 1'b1; sqe_mode = 2'b00;
        trigger_lock();
        tx_en = 1'b0;
        jab_disable = 1'b1;
        tick();
        chk("R9 lock ended on fall edge", int'(col_out), 0);
        for (int i = 0; i < int'(SD + SL + 2); i++) begin
            tick();
            if (col_out) count++;
        end
        chk("R9 no pulse from locked fall", count, 0);
        jab_disable = 1'b0;
        status_rd = 1'b1;
        tick();
        status_rd = 1'b0;
    endtask

    task automatic t_sqe_abort();
        int count = 0;
        speed_10 = 1'b1; sqe_mode = 2'b10;
        short_packet(3);
        tick();
        tx_en = 1'b1;
        for (int i = 0; i < int'(SD + SL + 2); i++) begin
            tick();
            if (col_out) count++;
        end
        chk("R10 pending pulse cancelled", count, 0);
        tx_en = 1'b0;
        sqe_probe(1'b1, "R10 R7 next fall pulses");
        sqe_mode = 2'b00;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        wait (cycles >= 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_jabber_boundary();
        t_quiet_release();
        t_flag_set_wins();
        t_disable();
        t_sqe_modes();
        t_sqe_in_lock();
        t_sqe_abort();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule